// File: doc/BRIEF.md
# Per-CPU Soft Interrupt and Level Output Unit

This unit serves one processor. It holds a 32-bit pending word for that processor, which carries three kinds of bits. The first kind is software interrupt requests, which the processor sets and clears through a small register port. The second is a broadcast level-15 flag that follows edges of a shared level-15 line. The third is a bit that follows this processor's timer line. The same word also reflects the hard interrupt levels that an upstream router currently maps to this processor. This lets software read one value and see everything that is asking for attention.

Every cycle the unit merges the soft bits, the broadcast and timer bits, and the enabled hard levels into a 16-bit level vector for levels 1 to 15. Bit 0 of the vector is always zero. The vector is registered. The unit also produces one-cycle rise and fall pulses for each level that changed, so the processor's interrupt lines can be raised and lowered on change. Mapping sources to levels and choosing the target processor are done upstream and arrive here only as input vectors and a target flag.

The register port takes requests on a valid/ready channel. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. A read returns its data on a separate response channel. The response stays on `rsp_valid`/`rsp_data`, unchanged, until `rsp_ready` is high on a clock edge. While a response is held, `req_ready` is low unless `rsp_ready` is high, so at most one response is ever outstanding. A write produces no response.

Top module: `softirq_lvl_unit`

## Requirements
- R1: After reset, the pending word reads zero, `lvl_out`, `lvl_rise` and `lvl_fall` are zero, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high exactly when no response is held or `rsp_ready` is high. An accepted read raises `rsp_valid` on the next cycle, and `rsp_valid` and `rsp_data` stay unchanged while `rsp_ready` is low.
- R3: A read of index 0 returns the pending word as it was at the accepting edge. A read of any other index returns zero.
- R4: A write to index 1 clears the pending bits that are set in the written data, but only within mask 0xFFFE8000 (bits 31:17 and bit 15). All other bits are left unchanged.
- R5: A write to index 2 sets the pending bits that are set in the written data, but only within mask 0xFFFE0000 (bits 31:17). All other bits are left unchanged.
- R6: An access takes effect only when all four bits of `req_be` are set. A partial write changes nothing, and a partial read returns zero.
- R7: Soft pending bit 17+k drives output level 1+k, for k = 0..14. This is the soft field shifted right by 16.
- R8: Pending bit 14 follows `timer_in` and cannot be cleared by a write. Pending bit 15 is set by a rising edge of `bcast15` and cleared by a falling edge or by a clear write. A rising edge in the same cycle as a clear write leaves the bit set.
- R9: Pending bits 15 and 14 drive output levels 15 and 14 only while `master_dis` is low.
- R10: `hard_en` bit n drives level n only while `is_target` is high and `master_dis` is low. While `is_target` is high, `hard_raw` bits 15:1 also show in pending bits 15:1, whatever `master_dis` is.
- R11: `lvl_out` bit 0 is always zero. Pending bits 0 and 16 always read zero.
- R12: `lvl_out` updates on the clock edge that follows any input change or accepted write. On that edge, `lvl_rise` and `lvl_fall` mark exactly the bits that went from 0 to 1 and from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Word index within the unit |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_data | output | 32 | Read response data |
| hard_raw | input | 16 | Mapped hard levels before masking (mirror only) |
| hard_en | input | 16 | Mapped hard levels after source masking |
| is_target | input | 1 | This processor is the hard interrupt target |
| master_dis | input | 1 | Global disable flag |
| bcast15 | input | 1 | Shared level-15 line |
| timer_in | input | 1 | This processor's timer line |
| lvl_out | output | 16 | Registered level vector, bit n = level n |
| lvl_rise | output | 16 | One-cycle pulse per level that turned on |
| lvl_fall | output | 16 | One-cycle pulse per level that turned off |

## Verification
The function pair that can fall in the same cycle is a clear write to bit 15 and a rising edge on the broadcast line. Both change pending bit 15 on the same edge, and the edge is meant to win. The bench provokes this by raising `bcast15` in the same cycle that it issues a write to index 1 with bit 15 set. It judges the result in two places: level 15 on `lvl_out` must be set on the next edge, and a following read must show pending bit 15 set. The bench then repeats the clear while the line is held high, and confirms that the bit drops and stays clear with no new edge.

// File: rtl/softirq_pkg.sv
package softirq_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_LVL    = 16;
  localparam int SOFT_SHIFT = 16;
  localparam int BE_W       = WORD_W / 8;

  typedef enum logic [1:0] {
    IDX_VIEW = 2'd0,
    IDX_CLR  = 2'd1,
    IDX_SET  = 2'd2
  } reg_idx_e;

  typedef struct packed {
    logic              clr;
    logic              set;
    logic [WORD_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/sil_regport.sv
module sil_regport
  import softirq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  input  logic [WORD_W-1:0] pend_view,
  output wr_cmd_t           cmd
);
  logic              accept;
  logic              full_word;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  assign full_word = &req_be;
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= (full_word && req_idx == IDX_W'(IDX_VIEW)) ? pend_view : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_comb begin
    cmd.clr  = accept && req_write && full_word && (req_idx == IDX_W'(IDX_CLR));
    cmd.set  = accept && req_write && full_word && (req_idx == IDX_W'(IDX_SET));
    cmd.data = req_wdata;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/sil_pending.sv
module sil_pending
  import softirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wr_cmd_t            cmd,
  input  logic               bcast15,
  input  logic               timer_in,
  input  logic               is_target,
  input  logic [NUM_LVL-1:0] hard_raw,
  output logic [NUM_LVL-2:0] soft_d,
  output logic               bc_d,
  output logic               tm_d,
  output logic [WORD_W-1:0]  pend_view
);
  localparam int SOFT_LSB = SOFT_SHIFT + 1;
  localparam int BC_BIT   = NUM_LVL - 1;
  localparam int TM_BIT   = NUM_LVL - 2;
  localparam logic [WORD_W-1:0] SOFT_MASK = ~((WORD_W'(1) << SOFT_LSB) - WORD_W'(1));
  localparam logic [WORD_W-1:0] SET_MASK  = SOFT_MASK;
  localparam logic [WORD_W-1:0] CLR_MASK  = SOFT_MASK | (WORD_W'(1) << BC_BIT);

  logic [WORD_W-1:0]  latch_q, latch_d;
  logic               tm_q;
  logic               line_q;
  logic [NUM_LVL-1:0] mir_q, mir_d;
  logic               bc_rise, bc_fall;

  assign bc_rise = bcast15 && !line_q;
  assign bc_fall = !bcast15 && line_q;

  // Soft field and broadcast bit share one word; the mask keeps the rest at 0.
  always_comb begin
    latch_d = latch_q;
    if (cmd.set) latch_d = latch_d | (cmd.data & SET_MASK);
    if (cmd.clr) latch_d = latch_d & ~(cmd.data & CLR_MASK);
    if (bc_fall) latch_d[BC_BIT] = 1'b0;
    if (bc_rise) latch_d[BC_BIT] = 1'b1;   // newest edge wins over a clear
    latch_d = latch_d & CLR_MASK;
  end

  assign mir_d  = is_target ? hard_raw : '0;
  assign soft_d = latch_d[WORD_W-1:SOFT_LSB];
  assign bc_d   = latch_d[BC_BIT];
  assign tm_d   = timer_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      tm_q    <= 1'b0;
      line_q  <= 1'b0;
      mir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      tm_q    <= tm_d;
      line_q  <= bcast15;
      mir_q   <= mir_d;
    end
  end

  always_comb begin
    pend_view = latch_q;
    pend_view[TM_BIT] = tm_q;
    pend_view[NUM_LVL-1:0] = pend_view[NUM_LVL-1:0] | mir_q;
    pend_view[0] = 1'b0;
  end
endmodule

// File: rtl/sil_merge.sv
module sil_merge
  import softirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-2:0] soft_d,
  input  logic               bc_d,
  input  logic               tm_d,
  input  logic               master_dis,
  input  logic               is_target,
  input  logic [NUM_LVL-1:0] hard_en,
  output logic [NUM_LVL-1:0] lvl_out,
  output logic [NUM_LVL-1:0] lvl_rise,
  output logic [NUM_LVL-1:0] lvl_fall
);
  localparam int BC_BIT = NUM_LVL - 1;
  localparam int TM_BIT = NUM_LVL - 2;

  logic [NUM_LVL-1:0] hard_vec;
  logic [NUM_LVL-1:0] nmi_vec;
  logic [NUM_LVL-1:0] lvl_d;
  logic [NUM_LVL-1:0] lvl_q, rise_q, fall_q;

  assign hard_vec = (is_target && !master_dis) ? hard_en : '0;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_nmi
    if (g == BC_BIT) begin : g_bc
      assign nmi_vec[g] = bc_d && !master_dis;
    end else if (g == TM_BIT) begin : g_tm
      assign nmi_vec[g] = tm_d && !master_dis;
    end else begin : g_none
      assign nmi_vec[g] = 1'b0;
    end
  end

  always_comb begin
    lvl_d    = {soft_d, 1'b0} | hard_vec | nmi_vec;
    lvl_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      rise_q <= lvl_d & ~lvl_q;
      fall_q <= lvl_q & ~lvl_d;
    end
  end

  assign lvl_out  = lvl_q;
  assign lvl_rise = rise_q;
  assign lvl_fall = fall_q;
endmodule

// File: rtl/softirq_lvl_unit.sv
module softirq_lvl_unit
  import softirq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_data,
  input  logic [NUM_LVL-1:0] hard_raw,
  input  logic [NUM_LVL-1:0] hard_en,
  input  logic               is_target,
  input  logic               master_dis,
  input  logic               bcast15,
  input  logic               timer_in,
  output logic [NUM_LVL-1:0] lvl_out,
  output logic [NUM_LVL-1:0] lvl_rise,
  output logic [NUM_LVL-1:0] lvl_fall
);
  wr_cmd_t            cmd;
  logic [WORD_W-1:0]  pend_view;
  logic [NUM_LVL-2:0] soft_d;
  logic               bc_d;
  logic               tm_d;

  sil_regport #(.IDX_W(IDX_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .pend_view (pend_view),
    .cmd       (cmd)
  );

  sil_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bcast15   (bcast15),
    .timer_in  (timer_in),
    .is_target (is_target),
    .hard_raw  (hard_raw),
    .soft_d    (soft_d),
    .bc_d      (bc_d),
    .tm_d      (tm_d),
    .pend_view (pend_view)
  );

  sil_merge u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_d     (soft_d),
    .bc_d       (bc_d),
    .tm_d       (tm_d),
    .master_dis (master_dis),
    .is_target  (is_target),
    .hard_en    (hard_en),
    .lvl_out    (lvl_out),
    .lvl_rise   (lvl_rise),
    .lvl_fall   (lvl_fall)
  );
endmodule

// File: rtl/softirq_lvl_unit_chk.sv
module softirq_lvl_unit_chk
  import softirq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [WORD_W-1:0]  rsp_data,
  input logic               master_dis,
  input logic               timer_in,
  input logic [NUM_LVL-1:0] lvl_out,
  input logic [NUM_LVL-1:0] lvl_rise,
  input logic [NUM_LVL-1:0] lvl_fall
);
  localparam int TM_BIT = NUM_LVL - 2;

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_read_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  p_timer_reaches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_in && !master_dis |=> lvl_out[TM_BIT]);

  p_no_level0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_out[0]);

  p_rise_edges_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_rise == (lvl_out & ~$past(lvl_out)));

  p_fall_edges_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_fall == ($past(lvl_out) & ~lvl_out));
endmodule

bind softirq_lvl_unit softirq_lvl_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .master_dis (master_dis),
  .timer_in   (timer_in),
  .lvl_out    (lvl_out),
  .lvl_rise   (lvl_rise),
  .lvl_fall   (lvl_fall)
);

// File: tb/tb_softirq_lvl_unit.sv
`timescale 1ns/1ps
module tb_softirq_lvl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = 4'hF;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [15:0] hard_raw = '0;
  logic [15:0] hard_en = '0;
  logic        is_target = 1'b0;
  logic        master_dis = 1'b0;
  logic        bcast15 = 1'b0;
  logic        timer_in = 1'b0;
  logic [15:0] lvl_out, lvl_rise, lvl_fall;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  softirq_lvl_unit dut (.*);

  typedef struct packed {
    logic        wr;
    logic [3:0]  idx;
    logic [31:0] wdata;
    logic        tgt;
    logic        md;
    logic        bc;
    logic        tm;
    logic [15:0] hen;
    logic [15:0] hraw;
    logic [15:0] exp_lvl;
    logic [31:0] exp_pend;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd2, 32'h0002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0002, 32'h0002_0000},
    '{1'b1, 4'd2, 32'h8001_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h8002, 32'h8002_0000},
    '{1'b0, 4'd0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0028, 16'h0828, 16'h802A, 32'h8002_0828},
    '{1'b0, 4'd0, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0028, 16'h0828, 16'h8002, 32'h8002_4828},
    '{1'b0, 4'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'hC002, 32'h8002_C000},
    '{1'b1, 4'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h4000, 32'h0000_4000},
    '{1'b1, 4'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] idx, input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = data; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
  endtask

  task automatic read_reg(input logic [3:0] idx, input logic [3:0] be, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_idx = idx; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
    check("R2 read response valid", {31'b0, rsp_valid}, 32'd1);
    data = rsp_data;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    logic [15:0] prev_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 lvl_out", {16'b0, lvl_out}, 32'h0);
    check("R1 rise/fall", {lvl_rise, lvl_fall}, 32'h0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 req_ready", {31'b0, req_ready}, 32'h1);
    read_reg(4'd0, 4'hF, rd);
    check("R1 pending after reset", rd, 32'h0);

    // Vector table: R4 R5 R7 R9 R10 R12
    prev_exp = '0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      is_target = VEC[i].tgt; master_dis = VEC[i].md; bcast15 = VEC[i].bc;
      timer_in = VEC[i].tm; hard_en = VEC[i].hen; hard_raw = VEC[i].hraw;
      if (VEC[i].wr) begin
        req_valid = 1'b1; req_write = 1'b1; req_idx = VEC[i].idx;
        req_wdata = VEC[i].wdata; req_be = 4'hF;
      end
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check($sformatf("R7/R9/R10 level vector %0d", i), {16'b0, lvl_out}, {16'b0, VEC[i].exp_lvl});
      check($sformatf("R12 rise vector %0d", i), {16'b0, lvl_rise}, {16'b0, VEC[i].exp_lvl & ~prev_exp});
      check($sformatf("R12 fall vector %0d", i), {16'b0, lvl_fall}, {16'b0, prev_exp & ~VEC[i].exp_lvl});
      read_reg(4'd0, 4'hF, rd);
      check($sformatf("R3/R4/R5 pending vector %0d", i), rd, VEC[i].exp_pend);
      prev_exp = VEC[i].exp_lvl;
    end

    // R3: other indices read zero
    write_reg(4'd2, 32'h0004_0000, 4'hF);
    read_reg(4'd1, 4'hF, rd);
    check("R3 index 1 reads zero", rd, 32'h0);
    read_reg(4'd3, 4'hF, rd);
    check("R3 index 3 reads zero", rd, 32'h0);

    // R6: partial accesses
    write_reg(4'd2, 32'h0008_0000, 4'h7);
    check("R6 partial write no level", {16'b0, lvl_out}, 32'h0004);
    read_reg(4'd0, 4'h3, rd);
    check("R6 partial read zero", rd, 32'h0);
    read_reg(4'd0, 4'hF, rd);
    check("R6 partial write ignored", rd, 32'h0004_0000);
    write_reg(4'd1, 32'h0004_0000, 4'hF);

    // R8: broadcast rise in the same cycle as a clear write
    @(negedge clk);
    bcast15 = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_idx = 4'd1; req_wdata = 32'h0000_8000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R8 rise beats clear (level)", {16'b0, lvl_out}, 32'h8000);
    read_reg(4'd0, 4'hF, rd);
    check("R8 rise beats clear (pending)", rd, 32'h0000_8000);
    // R8: clear while line held high stays clear
    write_reg(4'd1, 32'h0000_8000, 4'hF);
    check("R8 clear with line high", {16'b0, lvl_out}, 32'h0);
    repeat (2) @(negedge clk);
    read_reg(4'd0, 4'hF, rd);
    check("R8 stays clear", rd, 32'h0);
    @(negedge clk); bcast15 = 1'b0;
    @(negedge clk);

    // R11: bit 0 and bit 16 never set
    @(negedge clk);
    is_target = 1'b1; hard_en = 16'hFFFF; hard_raw = 16'hFFFF;
    @(negedge clk);
    check("R11 level 0 zero", {16'b0, lvl_out}, 32'hFFFE);
    read_reg(4'd0, 4'hF, rd);
    check("R11 pending bits 0,16", rd & 32'h0001_0001, 32'h0);
    check("R10 mirror shown", rd, 32'h0000_FFFE);
    @(negedge clk);
    is_target = 1'b0; hard_en = '0; hard_raw = '0;

    // R2: back-pressure on the response channel
    write_reg(4'd2, 32'h0010_0000, 4'hF);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_idx = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
    check("R2 req_ready low", {31'b0, req_ready}, 32'h0);
    rd2 = rsp_data;
    repeat (2) @(negedge clk);
    check("R2 data stable", rsp_data, rd2);
    check("R3 held data", rd2, 32'h0010_0000);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 response consumed", {31'b0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule